// File: doc/BRIEF.md
# Row Spare-Column Repair Controller

This block governs one row of programmable logic elements. Some positions in the row are set aside as spares. Which positions are spares is chosen each time the row is loaded, through a spare map that arrives with the configuration words. Each element has a fault line. When a working element raises its fault line, the controller takes the row offline and frees the faulty position by moving configuration words one step to the right.

The moves run one element per clock and start at the nearest spare to the right of the fault. Each word shifts right in turn until the faulty element's own word sits in its right-hand neighbour. The faulty position is then cleared and its route-select bit is set. That bit makes the element pass east-west signals straight through and steers its north/south links one column to the right. The row then resumes normal operation.

Each stretch of row between spares can absorb one fault. A fault that finds no unused spare to its right raises a sticky kill output, which hands the problem to a higher level. All repair state is volatile: reset or a new load wipes it.

Top module: `rrc_row_repair`

## Requirements
- R1: After reset, every physical configuration word is zero and the route-select bits, busy and kill are all low.
- R2: A load pulse copies the supplied words to the physical positions and clears every route-select bit, the record of used spares, and kill. Its results are visible the cycle after the load edge.
- R3: A fault is accepted from element f when f is not a spare, or is a spare already used by a repair, and f is not bypassed. If the first spare s with index greater than f is still unused, busy rises one cycle after the fault is sampled and stays high for exactly s-f+1 cycles.
- R4: Once the repair ends, position i holds the word previously at i-1 for every f<i<=s. Position f is zero and its route-select bit is 1. All other positions and bits are unchanged, and a route-select bit never falls except on load.
- R5: When several faults are accepted at once, the lowest-indexed element is repaired first. The others are handled afterwards if they are still asserted.
- R6: Fault lines have no effect on outputs while busy is high, on bypassed elements, or on spare positions that are still unused. The configuration words do not change while the row is idle.
- R7: A fault is unrepairable when it is accepted but no spare lies to its right, or when the first spare to its right is already used. In that case kill rises one cycle later, busy stays low and no configuration word changes. Kill stays high until the next load.
- R8: While kill is high, no fault starts a repair.
- R9: Spare positions are set by the spare map at load time (bit i = 1 makes element i a spare). A spare's physical word reads zero until a repair moves a word into it.
- R10: After any sequence of repairs, the words at non-bypassed positions that are not unused spares, read left to right, equal the loaded words of the non-spare positions in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load words and spare map, clear repair state |
| cfg_in | input | N_ELEM*CFG_W | Configuration words, element i in bits [i*CFG_W +: CFG_W] |
| spare_in | input | N_ELEM | Spare map, bit i = 1 marks element i as spare |
| fault_in | input | N_ELEM | Per-element fault lines, level sensitive |
| cfg_out | output | N_ELEM*CFG_W | Physical configuration words after repair |
| bypass_out | output | N_ELEM | Route-select: 1 = element transparent east-west, north/south moved right |
| busy_out | output | 1 | Row offline while a repair runs |
| kill_out | output | 1 | Sticky: a fault could not be repaired |

## Verification
The assertions assume load_en and rst are never asserted during a repair, so a shift run is never cut short. They also assume fault lines are ordinary level inputs whose timing needs no constraint. The stimulus raises load only while busy is low, and it holds fault masks steady between sample points. The one exception is a deliberate single-cycle pulse during a repair, which the row must ignore. Random spare maps and fault masks come from a fixed seed, so used spares, kills and multi-fault orderings recur across runs while staying reproducible.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } rrc_state_e;
endpackage

// File: rtl/rrc_fault_pick.sv
// Lowest-index selector over the accepted fault candidates.
module rrc_fault_pick #(
  parameter int N_ELEM = 8,
  parameter int IW     = 3
) (
  input  logic [N_ELEM-1:0] cand,
  output logic              vld,
  output logic [IW-1:0]     idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N_ELEM - 1; i >= 0; i--) begin
      if (cand[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rrc_spare_find.sv
// Finds the first spare position strictly to the right of from_idx.
module rrc_spare_find #(
  parameter int N_ELEM = 8,
  parameter int IW     = 3
) (
  input  logic [N_ELEM-1:0] spare_map,
  input  logic [IW-1:0]     from_idx,
  output logic              found,
  output logic [IW-1:0]     idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_ELEM - 1; i >= 0; i--) begin
      if (spare_map[i] && (i > int'(from_idx))) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rrc_cfg_bank.sv
// Physical configuration store: parallel load, one right move per cycle, clear.
module rrc_cfg_bank #(
  parameter int N_ELEM = 8,
  parameter int CFG_W  = 8,
  parameter int IW     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [N_ELEM*CFG_W-1:0] cfg_in,
  input  logic [N_ELEM-1:0]       spare_in,
  input  logic                    move_en,
  input  logic [IW-1:0]           move_dst,
  input  logic                    clr_en,
  input  logic [IW-1:0]           clr_idx,
  output logic [N_ELEM*CFG_W-1:0] cfg_out
);
  logic [CFG_W-1:0] bank [N_ELEM];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_slot
    localparam logic [IW-1:0] MY_IDX = IW'(g);
    logic [CFG_W-1:0] left_word;
    if (g == 0) begin : g_edge
      assign left_word = '0;
    end else begin : g_inner
      assign left_word = bank[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (load) begin
        bank[g] <= spare_in[g] ? '0 : cfg_in[g*CFG_W +: CFG_W];
      end else if (clr_en && (clr_idx == MY_IDX)) begin
        bank[g] <= '0;
      end else if (move_en && (move_dst == MY_IDX) && (g != 0)) begin
        bank[g] <= left_word;
      end
    end

    assign cfg_out[g*CFG_W +: CFG_W] = bank[g];
  end
endmodule

// File: rtl/rrc_row_repair.sv
module rrc_row_repair #(
  parameter int N_ELEM = 8,
  parameter int CFG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_en,
  input  logic [N_ELEM*CFG_W-1:0] cfg_in,
  input  logic [N_ELEM-1:0]       spare_in,
  input  logic [N_ELEM-1:0]       fault_in,
  output logic [N_ELEM*CFG_W-1:0] cfg_out,
  output logic [N_ELEM-1:0]       bypass_out,
  output logic                    busy_out,
  output logic                    kill_out
);
  import rrc_pkg::*;

  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1;

  rrc_state_e        state_q;
  logic [N_ELEM-1:0] spare_q, used_q, bypass_q;
  logic              killed_q, busy_q;
  logic [IW-1:0]     flt_q, tgt_q, ptr_q;

  logic [N_ELEM-1:0] live, cand;
  logic              pick_vld, sp_found;
  logic [IW-1:0]     pick_idx, sp_idx;
  logic              shift_last, move_en, clr_en;

  // Element carries a live configuration: ordinary slot or consumed spare.
  assign live = ~spare_q | used_q;
  assign cand = (state_q == ST_IDLE && !killed_q) ? (fault_in & live & ~bypass_q) : '0;

  rrc_fault_pick #(.N_ELEM(N_ELEM), .IW(IW)) u_pick (
    .cand (cand),
    .vld  (pick_vld),
    .idx  (pick_idx)
  );

  rrc_spare_find #(.N_ELEM(N_ELEM), .IW(IW)) u_find (
    .spare_map (spare_q),
    .from_idx  (pick_idx),
    .found     (sp_found),
    .idx       (sp_idx)
  );

  assign shift_last = (ptr_q == flt_q + IW'(1));
  assign move_en    = (state_q == ST_SHIFT);
  assign clr_en     = move_en && shift_last;

  rrc_cfg_bank #(.N_ELEM(N_ELEM), .CFG_W(CFG_W), .IW(IW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .cfg_in   (cfg_in),
    .spare_in (spare_in),
    .move_en  (move_en),
    .move_dst (ptr_q),
    .clr_en   (clr_en),
    .clr_idx  (flt_q),
    .cfg_out  (cfg_out)
  );

  always_ff @(posedge clk) begin
    if (rst || load_en) begin
      state_q  <= ST_IDLE;
      spare_q  <= rst ? '0 : spare_in;
      used_q   <= '0;
      bypass_q <= '0;
      killed_q <= 1'b0;
      busy_q   <= 1'b0;
      flt_q    <= '0;
      tgt_q    <= '0;
      ptr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pick_vld) begin
            if (!sp_found || used_q[sp_idx]) begin
              killed_q <= 1'b1;
            end else begin
              flt_q   <= pick_idx;
              tgt_q   <= sp_idx;
              ptr_q   <= sp_idx;
              busy_q  <= 1'b1;
              state_q <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (shift_last) begin
            bypass_q[flt_q] <= 1'b1;
            used_q[tgt_q]   <= 1'b1;
            state_q         <= ST_DONE;
          end else begin
            ptr_q <= ptr_q - IW'(1);
          end
        end
        ST_DONE: begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign bypass_out = bypass_q;
  assign busy_out   = busy_q;
  assign kill_out   = killed_q;
endmodule

// File: rtl/rrc_row_repair_chk.sv
module rrc_row_repair_chk #(
  parameter int N_ELEM = 8,
  parameter int CFG_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    load_en,
  input logic [N_ELEM*CFG_W-1:0] cfg_out,
  input logic [N_ELEM-1:0]       bypass_out,
  input logic                    busy_out,
  input logic                    kill_out
);
  localparam int RW = $clog2(N_ELEM + 2) + 1;
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst || load_en || !busy_out) busy_run <= '0;
    else                             busy_run <= busy_run + RW'(1);
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RW'(N_ELEM));

  // R7
  kill_idle_chk: assert property (@(posedge clk) disable iff (rst)
    kill_out |-> !busy_out);

  // R7
  kill_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (kill_out && !load_en) |=> kill_out);

  // R4
  bypass_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ((bypass_out & $past(bypass_out)) == $past(bypass_out)));

  // R4
  bypass_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_en) && !$past(rst) && (bypass_out != $past(bypass_out))) |-> busy_out);

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !busy_out) |=> $stable(cfg_out));
endmodule

bind rrc_row_repair rrc_row_repair_chk #(.N_ELEM(N_ELEM), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/rrc_row_repair_test.sv
module rrc_row_repair_test;
  localparam int NE = 8;
  localparam int CW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_en = 1'b0;
  logic [NE*CW-1:0]  cfg_in = '0;
  logic [NE-1:0]     spare_in = '0;
  logic [NE-1:0]     fault_in = '0;
  logic [NE*CW-1:0]  cfg_out;
  logic [NE-1:0]     bypass_out;
  logic              busy_out, kill_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Bench model of the row
  logic [CW-1:0] m_cfg [NE];
  logic [NE-1:0] m_sp, m_used, m_byp;
  bit            m_kill;
  logic [NE*CW-1:0] m_orig;   // original non-spare words packed from the left
  int               m_norig;

  always #2 clk = ~clk;  // 250 MHz

  rrc_row_repair #(.N_ELEM(NE), .CFG_W(CW)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .cfg_in(cfg_in),
    .spare_in(spare_in), .fault_in(fault_in), .cfg_out(cfg_out),
    .bypass_out(bypass_out), .busy_out(busy_out), .kill_out(kill_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NE*CW-1:0] exp_flat();
    logic [NE*CW-1:0] v;
    for (int i = 0; i < NE; i++) v[i*CW +: CW] = m_cfg[i];
    return v;
  endfunction

  function automatic logic [NE*CW-1:0] live_list(input logic [NE*CW-1:0] phys);
    logic [NE*CW-1:0] v = '0;
    int k = 0;
    for (int i = 0; i < NE; i++) begin
      if ((!m_sp[i] || m_used[i]) && !m_byp[i]) begin
        v[k*CW +: CW] = phys[i*CW +: CW];
        k++;
      end
    end
    return v;
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [NE-1:0] sp);
    m_norig = 0;
    m_orig  = '0;
    for (int i = 0; i < NE; i++) begin
      logic [CW-1:0] w = CW'($urandom());
      cfg_in[i*CW +: CW] = w;
      m_cfg[i] = sp[i] ? '0 : w;
      if (!sp[i]) begin
        m_orig[m_norig*CW +: CW] = w;
        m_norig++;
      end
    end
    spare_in = sp;
    load_en  = 1'b1;
    cyc();
    load_en  = 1'b0;
    m_sp = sp; m_used = '0; m_byp = '0; m_kill = 1'b0;
    chk(cfg_out == exp_flat(), "R2 load words", cfg_out, exp_flat());
    chk(bypass_out == '0 && kill_out == 1'b0, "R2 state cleared", {bypass_out, kill_out}, 0);
    for (int i = 0; i < NE; i++)
      if (sp[i]) chk(cfg_out[i*CW +: CW] == '0, "R9 spare unconfigured", cfg_out[i*CW +: CW], 0);
  endtask

  // Applies a held fault mask and follows every repair or kill it causes.
  task automatic fault_seq(input logic [NE-1:0] mask);
    fault_in = mask;
    for (int iter = 0; iter < NE + 2; iter++) begin
      logic [NE-1:0] elig;
      int f, s;
      elig = m_kill ? '0 : (mask & (~m_sp | m_used) & ~m_byp);
      if (elig == '0) begin
        // R8 when killed, otherwise R6: nothing changes
        repeat (3) cyc();
        chk(busy_out == 1'b0, m_kill ? "R8 no repair" : "R6 ignored busy", busy_out, 0);
        chk(cfg_out == exp_flat() && bypass_out == m_byp,
            m_kill ? "R8 no change" : "R6 ignored cfg", cfg_out, exp_flat());
        break;
      end
      f = -1;
      for (int i = NE - 1; i >= 0; i--) if (elig[i]) f = i;   // R5 lowest first
      s = -1;
      for (int i = NE - 1; i > f; i--) if (m_sp[i]) s = i;
      if (s < 0 || m_used[s]) begin
        cyc();
        m_kill = 1'b1;
        chk(kill_out == 1'b1, "R7 kill raised", kill_out, 1);
        chk(busy_out == 1'b0, "R7 busy low", busy_out, 0);
        chk(cfg_out == exp_flat(), "R7 cfg unchanged", cfg_out, exp_flat());
      end else begin
        int cnt = 0;
        cyc();
        while (busy_out && cnt < 40) begin
          cnt++;
          cyc();
        end
        chk(cnt == s - f + 1, "R3 busy length", cnt, s - f + 1);
        for (int i = s; i > f; i--) m_cfg[i] = m_cfg[i-1];
        m_cfg[f] = '0;
        m_byp[f] = 1'b1;
        m_used[s] = 1'b1;
        chk(cfg_out == exp_flat(), "R4 shifted words", cfg_out, exp_flat());
        chk(bypass_out == m_byp, "R5 R4 route select", bypass_out, m_byp);
        chk(live_list(cfg_out) == m_orig, "R10 logical order", live_list(cfg_out), m_orig);
      end
    end
    fault_in = '0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(cfg_out == '0 && bypass_out == '0, "R1 reset outputs", {cfg_out, bypass_out}, 0);
    chk(busy_out == 1'b0 && kill_out == 1'b0, "R1 reset flags", {busy_out, kill_out}, 0);

    // Spares at 3 and 7
    do_load(8'b1000_1000);
    fault_seq(8'b0000_0010);   // repair f=1 into spare 3
    fault_seq(8'b0000_0100);   // same segment again: R7 kill
    fault_seq(8'b0010_0000);   // R8 ignored while killed

    // Spares at 2 and 6: unused spare fault, then R5 ordering
    do_load(8'b0100_0100);
    fault_seq(8'b0000_0100);   // R6 unused spare
    fault_seq(8'b0001_0001);   // f=0 then f=4

    // R6 fault pulse during busy
    do_load(8'b1001_0000);
    fault_in = 8'b0000_0010;
    cyc();
    chk(busy_out == 1'b1, "R3 busy rises", busy_out, 1);
    fault_in = 8'b0010_0010;
    cyc();
    fault_in = 8'b0000_0010;
    while (busy_out) cyc();
    fault_in = '0;
    for (int i = 4; i > 1; i--) m_cfg[i] = m_cfg[i-1];
    m_cfg[1] = '0; m_byp[1] = 1'b1; m_used[4] = 1'b1;
    repeat (3) cyc();
    chk(bypass_out == 8'b0000_0010, "R6 pulse during busy ignored", bypass_out, 8'b0000_0010);
    chk(cfg_out == exp_flat(), "R6 cfg after pulse", cfg_out, exp_flat());

    // R7 no spare to the right
    do_load(8'b0000_1000);
    fault_seq(8'b1000_0000);

    // Constrained random rounds
    for (int r = 0; r < 20; r++) begin
      logic [NE-1:0] sp = NE'($urandom()) & NE'($urandom());
      do_load(sp);
      for (int k = 0; k < 3; k++) begin
        logic [NE-1:0] fm = NE'($urandom()) & NE'($urandom()) & NE'($urandom());
        fault_seq(fm);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule